// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a computer-operating-properly watchdog that runs from the bus clock. A free-running power-of-two prescaler produces a slow tick. A second counter, whose length comes from a three-bit rate code, counts those ticks. When that count expires, the block requests a system reset. Software prevents the reset by writing an ordered key pair to a service register: first 0x55, then 0xAA. Any other value written there is treated as runaway code and requests a reset at once.

A small control register holds the rate code, a force-reset bit and a disable-resets bit. The `special_mode` input relaxes the write rules for test:

- In normal mode the rate code can be set only once, and the force and disable bits cannot be written.
- In special mode every field is writable, and `test_bypass` shortens the prescaler to its last two stages.

Every reset request is a single-cycle pulse. It comes with exactly one cause pulse.

Top module: `keyed_watchdog`

## Requirements
- R1: With prescaler period P = 2^PRE_LOG2, rate codes 1..7 time out after 1, 4, 16, 64, 256, 512 and 1024 prescaler ticks. This gives total divides of P, 4P, 16P, 64P, 256P, 512P and 1024P.
- R2: Rate code 0 stops the timeout count, so no timeout reset ever occurs.
- R3: Writing 0x55 and later 0xAA to the service register (`wr_addr`=1) restarts the timeout count. Other cycles may pass between the two writes, and a repeated 0x55 leaves the block armed.
- R4: An 0xAA write with no pending 0x55 neither restarts the count nor requests a reset.
- R5: A service-register write whose data is neither 0x55 nor 0xAA raises `rst_req` and `cause_key` on the next clock edge.
- R6: Reading the service register (`rd_addr`=1) returns 0x00. Reading the control register (`rd_addr`=0) returns {0, disable, 000, rate}.
- R7: The control register layout is: bit 7 force, bit 6 disable, bits 2:0 rate. In normal mode the rate can be written only by the first control write since reset or since the last `rst_req` pulse. In special mode it can be written any number of times.
- R8: A control write with bit 7 set, made in special mode with a nonzero rate in bits 2:0, raises `rst_req` and `cause_force` on the next edge. In normal mode the force bit is ignored.
- R9: While the disable bit is 1, no source produces `rst_req`. The disable bit can be written only in special mode.
- R10: `rst_req` is a one-cycle pulse. Each pulse comes with exactly one cause pulse, chosen in the priority order key, force, timeout. The pulse clears the tick count, the arm flag and the write-once lock.
- R11: In special mode with `test_bypass` high, the prescaler period becomes 4 clocks.
- R12: Servicing does not clear the prescaler. The timeout therefore falls between (N-1)·P and N·P clocks after the count restarts, where N is the tick count for the rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| special_mode | input | 1 | 1 = special test mode write rules |
| test_bypass | input | 1 | Shortens the prescaler to 4 clocks (special mode only) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control register, 1 = service register |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | 0 = control register, 1 = service register |
| rd_data | output | 8 | Combinational read data |
| rst_req | output | 1 | One-cycle system reset request |
| cause_timeout | output | 1 | Pulse: reset came from the timeout |
| cause_key | output | 1 | Pulse: reset came from a bad service write |
| cause_force | output | 1 | Pulse: reset came from the force bit |

## Verification
Key-error and force resets are due one edge after the write. The bench drives each write on a falling edge and samples `rst_req` and the cause pulse on the very next falling edge, then confirms the pulse has gone one edge later. Timeouts depend on the free-running prescaler phase. For them the bench counts falling edges from the write that enables or restarts the count, and accepts any count within the R12 window (with one cycle of slack) computed from P and the rate. The bench uses a 16-clock prescaler so those windows stay short. Reads are combinational and are sampled in the same half-cycle the address is applied.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int PRE_LOG2 = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       special_mode,
  input  logic       test_bypass,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_addr,
  output logic [7:0] rd_data,
  output logic       rst_req,
  output logic       cause_timeout,
  output logic       cause_key,
  output logic       cause_force
);
  localparam int CW = 11;
  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  logic [PRE_LOG2-1:0] pre_cnt;
  logic [CW-1:0]       div_cnt;
  logic [CW-1:0]       limit;
  logic [2:0]          rate_q;
  logic                dis_q, lock_q, armed_q;

  wire ctrl_wr  = wr_en & ~wr_addr;
  wire svc_wr   = wr_en & wr_addr;
  wire arm_wr   = svc_wr & (wr_data == KEY_ARM);
  wire fire_wr  = svc_wr & (wr_data == KEY_FIRE);
  wire serviced = fire_wr & armed_q;
  wire enabled  = rate_q != 3'd0;
  wire tick     = (special_mode & test_bypass) ? &pre_cnt[1:0] : &pre_cnt;
  wire rate_ok  = special_mode | ~lock_q;

  always_comb begin
    case (rate_q)
      3'd1:    limit = 11'd1;
      3'd2:    limit = 11'd4;
      3'd3:    limit = 11'd16;
      3'd4:    limit = 11'd64;
      3'd5:    limit = 11'd256;
      3'd6:    limit = 11'd512;
      3'd7:    limit = 11'd1024;
      default: limit = 11'd1;
    endcase
  end

  wire key_ev   = svc_wr & ~arm_wr & ~fire_wr;
  wire force_ev = ctrl_wr & special_mode & wr_data[7] & (wr_data[2:0] != 3'd0);
  wire to_ev    = enabled & tick & ~serviced & (div_cnt >= limit - 11'd1);
  wire fire     = (key_ev | force_ev | to_ev) & ~dis_q;

  assign rd_data = rd_addr ? 8'h00 : {1'b0, dis_q, 3'b000, rate_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_cnt <= '0;
    else        pre_cnt <= pre_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= 3'd0;
      dis_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      if (ctrl_wr & rate_ok)      rate_q <= wr_data[2:0];
      if (ctrl_wr & special_mode) dis_q  <= wr_data[6];
      if (fire)                         lock_q <= 1'b0;
      else if (ctrl_wr & ~special_mode) lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      armed_q <= 1'b0;
    end else begin
      if (fire | serviced | to_ev | ~enabled) div_cnt <= '0;
      else if (tick)                          div_cnt <= div_cnt + 1'b1;
      if (fire | serviced) armed_q <= 1'b0;
      else if (arm_wr)     armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req       <= 1'b0;
      cause_key     <= 1'b0;
      cause_force   <= 1'b0;
      cause_timeout <= 1'b0;
    end else begin
      rst_req       <= fire;
      cause_key     <= key_ev & ~dis_q;
      cause_force   <= force_ev & ~key_ev & ~dis_q;
      cause_timeout <= to_ev & ~key_ev & ~force_ev & ~dis_q;
    end
  end

  a_r10_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req == (cause_key | cause_force | cause_timeout)) &&
    $onehot0({cause_key, cause_force, cause_timeout}));
  a_r9_disable_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q |=> !rst_req);
  a_r7_lock_holds_rate: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q && !special_mode |=> $stable(rate_q));
  a_r8_force_special_only: assert property (@(posedge clk) disable iff (!rst_n)
    cause_force |-> $past(special_mode));
  a_r2_timeout_needs_rate: assert property (@(posedge clk) disable iff (!rst_n)
    cause_timeout |-> $past(enabled));
  a_r5_key_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    cause_key |-> $past(svc_wr));
endmodule

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/1ps
module keyed_watchdog_test;
  localparam int PL = 4;
  localparam int PS = 1 << PL;

  logic clk = 0, rst_n = 0, special_mode = 0, test_bypass = 0;
  logic wr_en = 0, wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic rst_req, cause_timeout, cause_key, cause_force;
  int checks = 0, errors = 0, pulses = 0;

  keyed_watchdog #(.PRE_LOG2(PL)) uut (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .test_bypass(test_bypass),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .rst_req(rst_req), .cause_timeout(cause_timeout),
    .cause_key(cause_key), .cause_force(cause_force));

  always #2 clk = ~clk;
  always @(negedge clk) if (rst_req) pulses++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic sm, input logic byp);
    rst_n = 0; special_mode = sm; test_bypass = byp;
    repeat (3) @(negedge clk);
    rst_n = 1; pulses = 0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    rd_addr = a; #0.1; d = rd_data;
  endtask

  task automatic wait_rst(input int max, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!rst_req && n < max);
  endtask

  task automatic t_reset_state;
    logic [7:0] d;
    do_reset(0, 0);
    rd(0, d); check(d == 8'h00, "R6 ctrl after reset", d, 0);
    rd(1, d); check(d == 8'h00, "R6 service reads zero", d, 0);
    check(!rst_req && !cause_key && !cause_force && !cause_timeout, "R10 idle outputs", rst_req, 0);
  endtask

  task automatic t_off;
    do_reset(0, 0);
    repeat (1200) @(negedge clk);
    check(pulses == 0, "R2 rate 0 never times out", pulses, 0);
  endtask

  task automatic t_timeout(input logic sm, input int code, input int ticks, input int per, input string req);
    int n;
    do_reset(sm, sm);
    if (!sm) test_bypass = 0;
    wr(0, 8'(code));
    wait_rst(ticks * per + 10, n);
    check(n >= (ticks - 1) * per + 1 && n <= ticks * per + 2, req, n, ticks * per);
    check(cause_timeout && !cause_key && !cause_force, "R10 timeout cause", cause_timeout, 1);
    @(negedge clk);
    check(!rst_req && !cause_timeout, "R10 single-cycle pulse", rst_req, 0);
  endtask

  task automatic t_service;
    int n;
    do_reset(1, 0);
    wr(0, 8'h02);
    for (int i = 0; i < 8; i++) begin
      wr(1, 8'h55);
      if (i % 2 == 1) wr(1, 8'h55);
      repeat (8) @(negedge clk);
      wr(1, 8'hAA);
      repeat (15) @(negedge clk);
    end
    check(pulses == 0, "R3 serviced watchdog stays quiet", pulses, 0);
    wait_rst(100, n);
    check(rst_req && cause_timeout, "R3 timeout after servicing stops", n, 4 * PS);
  endtask

  task automatic t_unarmed;
    int n;
    do_reset(1, 0);
    wr(0, 8'h02);
    repeat (38) @(negedge clk);
    wr(1, 8'hAA);
    check(!rst_req, "R4 lone 0xAA causes no reset", rst_req, 0);
    wait_rst(120, n);
    n += 39;
    check(rst_req && n <= 4 * PS + 2, "R4 lone 0xAA does not restart count", n, 4 * PS);
  endtask

  task automatic t_badkey;
    do_reset(0, 0);
    wr(1, 8'h12);
    check(rst_req && cause_key && !cause_force && !cause_timeout, "R5 bad key resets", cause_key, 1);
    @(negedge clk);
    check(!rst_req, "R10 key pulse ends", rst_req, 0);
    wr(1, 8'h00);
    check(rst_req && cause_key, "R5 zero key resets", cause_key, 1);
  endtask

  task automatic t_lock;
    logic [7:0] d; int n;
    do_reset(0, 0);
    wr(0, 8'h01); wr(0, 8'h03);
    rd(0, d); check(d == 8'h01, "R7 normal write-once", d, 1);
    wr(0, 8'h40);
    rd(0, d); check(d == 8'h01, "R9 disable not writable in normal", d, 1);
    wait_rst(40, n);
    @(negedge clk);
    wr(0, 8'h03);
    rd(0, d); check(d == 8'h03, "R7 lock cleared by reset pulse", d, 3);
    do_reset(1, 0);
    wr(0, 8'h01); wr(0, 8'h05);
    rd(0, d); check(d == 8'h05, "R7 special rewrite", d, 5);
  endtask

  task automatic t_force;
    logic [7:0] d;
    do_reset(0, 0);
    wr(0, 8'h83);
    check(!rst_req, "R8 force ignored in normal", rst_req, 0);
    rd(0, d); check(d == 8'h03, "R8 rate taken without force", d, 3);
    do_reset(1, 0);
    wr(0, 8'h80);
    check(!rst_req, "R8 force with rate 0 ignored", rst_req, 0);
    wr(0, 8'h82);
    check(rst_req && cause_force && !cause_key && !cause_timeout, "R8 force resets in special", cause_force, 1);
  endtask

  task automatic t_disable;
    logic [7:0] d;
    do_reset(1, 0);
    wr(0, 8'h41);
    rd(0, d); check(d == 8'h41, "R9 disable readback", d, 8'h41);
    repeat (100) @(negedge clk);
    wr(1, 8'h33);
    wr(0, 8'hC1);
    check(pulses == 0, "R9 disable blocks all sources", pulses, 0);
  endtask

  initial begin
    t_reset_state();
    t_off();
    t_timeout(0, 1, 1, PS, "R1 rate 1 window");
    t_timeout(1, 2, 4, 4, "R11 bypass rate 2 window");
    special_mode = 1; test_bypass = 0;
    t_timeout(0, 2, 4, PS, "R12 rate 2 window");
    t_timeout(0, 3, 16, PS, "R1 rate 3 window");
    t_timeout(1, 1, 1, 4, "R11 bypass rate 1 window");
    t_service();
    t_unarmed();
    t_badkey();
    t_lock();
    t_force();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule